// File: doc/BRIEF.md
# Macro Engine ALU with Carry Flag

This block is the arithmetic and logic stage of a small command-macro engine. The result path is purely combinational. An opcode and two operands enter, and a result of the same width comes out. There are four arithmetic operations that use a carry, and five bitwise operations.

One flag register holds the carry between instructions. It lets a sequence of add-with-carry or subtract-with-borrow instructions build arithmetic wider than one word. For subtraction the flag means "no borrow".

The flag changes only on a clock edge where the sequencer asserts the execute strobe. The sequencer clears the flag at the start of each macro with a synchronous clear input. An opcode with no defined meaning gives a zero result, raises an illegal indication and leaves the flag untouched.

Top module: `macro_alu`

## Requirements
- R1: Opcode 0 gives A+B and opcode 2 gives A-B, both modulo 2^32.
- R2: Opcode 1 gives A+B+F modulo 2^32, where F is the current carry flag.
- R3: When exec_en is high on a clock edge with opcode 0 or 1, the flag takes the carry out of the full sum, which is 1 when the sum is at least 2^32.
- R4: When exec_en is high on a clock edge with opcode 2, the flag becomes 1 exactly when A >= B (unsigned), meaning no borrow.
- R5: Opcode 3 gives A-B-1 when F is 0 and A-B when F is 1. On an enabled edge the flag becomes 1 exactly when A >= B + (1-F) (unsigned).
- R6: Opcodes 8..12 give A xor B, A or B, A and B, A and not B, and not (A and B), in that order. They leave the flag unchanged even when enabled.
- R7: Opcodes 4..7 and 13..31 drive result 0 and illegal 1, and leave the flag unchanged. All other opcodes drive illegal 0.
- R8: When exec_en is low on a clock edge, the flag keeps its value whatever the opcode.
- R9: start_clr high on a clock edge clears the flag, even when exec_en is high on the same edge.
- R10: rst_n low clears the flag asynchronously. After reset the flag reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_clr | input | 1 | Synchronous clear of the carry flag at macro start |
| exec_en | input | 1 | Execute strobe; lets the flag update on this edge |
| op | input | 5 | Operation code |
| opa | input | 32 | First operand A |
| opb | input | 32 | Second operand B |
| result | output | 32 | Combinational result |
| illegal | output | 1 | High for an undefined opcode |
| carry | output | 1 | Current carry flag |

## Verification
The only internal state is the carry flag. A wrong flag value shows on the carry port one edge after the instruction that produced it. It shows again in the same cycle on the result of any following add-with-carry or subtract-with-borrow, where it shifts the sum by exactly one.

A flag that wrongly moved on a logic op, an illegal op or a disabled edge is visible on carry one edge later. The bench compares carry after every edge and chains carry-consuming operations, so a bad flag is reported within one cycle.

// File: rtl/macro_alu_pkg.sv
package macro_alu_pkg;

  localparam int unsigned OPC_W = 5;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADD  = 5'd0,
    OPC_ADC  = 5'd1,
    OPC_SUB  = 5'd2,
    OPC_SBB  = 5'd3,
    OPC_XOR  = 5'd8,
    OPC_OR   = 5'd9,
    OPC_AND  = 5'd10,
    OPC_ANDN = 5'd11,
    OPC_NAND = 5'd12
  } opc_e;

  // selector inside the arithmetic unit
  typedef enum logic [1:0] {
    AR_ADD = 2'd0,
    AR_ADC = 2'd1,
    AR_SUB = 2'd2,
    AR_SBB = 2'd3
  } arith_sel_e;

  // selector inside the bitwise unit
  typedef enum logic [2:0] {
    LG_XOR  = 3'd0,
    LG_OR   = 3'd1,
    LG_AND  = 3'd2,
    LG_ANDN = 3'd3,
    LG_NAND = 3'd4
  } logic_sel_e;

  typedef struct packed {
    logic       arith;
    logic       bitwise;
    logic       bad;
    arith_sel_e asel;
    logic_sel_e lsel;
  } dec_t;

  // Subtraction is folded onto one adder: A + ~B + cin.
  // Returns the second operand as the adder sees it.
  function automatic logic [31:0] adder_b(input arith_sel_e s, input logic [31:0] b);
    return (s == AR_SUB || s == AR_SBB) ? ~b : b;
  endfunction

  // Carry into the adder for each arithmetic variant.
  function automatic logic adder_cin(input arith_sel_e s, input logic flag);
    case (s)
      AR_ADD:  return 1'b0;
      AR_ADC:  return flag;
      AR_SUB:  return 1'b1;
      default: return flag;
    endcase
  endfunction

endpackage

// File: rtl/malu_decode.sv
module malu_decode
  import macro_alu_pkg::*;
(
  input  logic [OPC_W-1:0] op,
  output dec_t             dec
);
  always_comb begin
    dec       = '0;
    dec.asel  = AR_ADD;
    dec.lsel  = LG_XOR;
    case (op)
      OPC_ADD:  begin dec.arith = 1'b1; dec.asel = AR_ADD; end
      OPC_ADC:  begin dec.arith = 1'b1; dec.asel = AR_ADC; end
      OPC_SUB:  begin dec.arith = 1'b1; dec.asel = AR_SUB; end
      OPC_SBB:  begin dec.arith = 1'b1; dec.asel = AR_SBB; end
      OPC_XOR:  begin dec.bitwise = 1'b1; dec.lsel = LG_XOR; end
      OPC_OR:   begin dec.bitwise = 1'b1; dec.lsel = LG_OR; end
      OPC_AND:  begin dec.bitwise = 1'b1; dec.lsel = LG_AND; end
      OPC_ANDN: begin dec.bitwise = 1'b1; dec.lsel = LG_ANDN; end
      OPC_NAND: begin dec.bitwise = 1'b1; dec.lsel = LG_NAND; end
      default:  dec.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/malu_arith.sv
module malu_arith
  import macro_alu_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  arith_sel_e    sel,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          flag,
  output logic [DW-1:0] sum,
  output logic          cout
);
  localparam int unsigned SW = DW + 1;

  logic [DW-1:0] b_eff;
  logic          cin;
  logic [SW-1:0] full;

  always_comb begin
    b_eff = adder_b(sel, b[31:0]);
    cin   = adder_cin(sel, flag);
    full  = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, cin};
  end

  assign sum  = full[DW-1:0];
  assign cout = full[DW];
endmodule

// File: rtl/malu_logic.sv
module malu_logic
  import macro_alu_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic_sel_e    sel,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  always_comb begin
    case (sel)
      LG_XOR:  y = a ^ b;
      LG_OR:   y = a | b;
      LG_AND:  y = a & b;
      LG_ANDN: y = a & ~b;
      LG_NAND: y = ~(a & b);
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/malu_flag.sv
module malu_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic upd,
  input  logic nxt,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (clr) q <= 1'b0;
    else if (upd) q <= nxt;
  end
endmodule

// File: rtl/macro_alu.sv
module macro_alu
  import macro_alu_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_clr,
  input  logic             exec_en,
  input  logic [OPC_W-1:0] op,
  input  logic [DW-1:0]    opa,
  input  logic [DW-1:0]    opb,
  output logic [DW-1:0]    result,
  output logic             illegal,
  output logic             carry
);
  dec_t          dec;
  logic [DW-1:0] arith_y;
  logic [DW-1:0] logic_y;
  logic          arith_co;
  logic          dec_arith;
  logic          flag_upd;

  malu_decode u_dec (.op(op), .dec(dec));

  malu_arith #(.DW(DW)) u_arith (
    .sel(dec.asel), .a(opa), .b(opb), .flag(carry),
    .sum(arith_y), .cout(arith_co)
  );

  malu_logic #(.DW(DW)) u_logic (
    .sel(dec.lsel), .a(opa), .b(opb), .y(logic_y)
  );

  assign dec_arith = dec.arith;
  assign flag_upd  = exec_en & dec.arith;

  malu_flag u_flag (
    .clk(clk), .rst_n(rst_n), .clr(start_clr),
    .upd(flag_upd), .nxt(arith_co), .q(carry)
  );

  always_comb begin
    if (dec.arith)        result = arith_y;
    else if (dec.bitwise) result = logic_y;
    else                  result = '0;
  end

  assign illegal = dec.bad;
endmodule

// File: rtl/macro_alu_chk.sv
module macro_alu_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_clr,
  input logic          exec_en,
  input logic          illegal,
  input logic [DW-1:0] result,
  input logic          carry,
  input logic          is_arith,
  input logic          arith_cout
);
  // R7
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> result == '0);

  // R7
  illegal_not_arith_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !is_arith);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_en && !start_clr) |=> $stable(carry));

  // R6
  nonarith_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && !is_arith && !start_clr) |=> $stable(carry));

  // R3
  arith_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && is_arith && !start_clr) |=> carry == $past(arith_cout));

  // R9
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_clr |=> !carry);
endmodule

bind macro_alu macro_alu_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_clr(start_clr), .exec_en(exec_en),
  .illegal(illegal), .result(result), .carry(carry),
  .is_arith(dec_arith), .arith_cout(arith_co)
);

// File: tb/tb_macro_alu.sv
module tb_macro_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_clr = 1'b0;
  logic        exec_en = 1'b0;
  logic [4:0]  op = '0;
  logic [31:0] opa = '0, opb = '0;
  logic [31:0] result;
  logic        illegal, carry;

  int total = 0, bad = 0;
  bit done = 0;
  logic mflag = 1'b0;

  always #10 clk = ~clk;

  macro_alu dut (.clk(clk), .rst_n(rst_n), .start_clr(start_clr), .exec_en(exec_en),
    .op(op), .opa(opa), .opb(opb), .result(result), .illegal(illegal), .carry(carry));

  function automatic bit ref_legal(input logic [4:0] o);
    return (o <= 5'd3) || (o >= 5'd8 && o <= 5'd12);
  endfunction

  function automatic bit ref_arith(input logic [4:0] o);
    return o <= 5'd3;
  endfunction

  function automatic logic [31:0] ref_res(input logic [4:0] o, input logic [31:0] a,
                                          input logic [31:0] b, input logic f);
    longint unsigned la = a, lb = b, lf = f;
    case (o)
      5'd0: return 32'(la + lb);
      5'd1: return 32'(la + lb + lf);
      5'd2: return 32'(la - lb);
      5'd3: return 32'(la - lb - (1 - lf));
      5'd8: return a ^ b;
      5'd9: return a | b;
      5'd10: return a & b;
      5'd11: return a & ~b;
      5'd12: return ~(a & b);
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic ref_cy(input logic [4:0] o, input logic [31:0] a,
                                  input logic [31:0] b, input logic f);
    longint unsigned la = a, lb = b, lf = f;
    case (o)
      5'd0: return (la + lb) > 64'hFFFF_FFFF;
      5'd1: return (la + lb + lf) > 64'hFFFF_FFFF;
      5'd2: return la >= lb;
      5'd3: return la >= (lb + 1 - lf);
      default: return f;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [4:0] o, input bit en, input bit clr);
    if (clr) return "R9";
    if (!ref_legal(o)) return "R7";
    if (!en) return "R8";
    case (o)
      5'd0: return "R3";
      5'd1: return "R2";
      5'd2: return "R4";
      5'd3: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic step(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b,
                      input bit en, input bit clr);
    logic [31:0] er;
    logic        ec;
    string       t;
    t = tag_of(o, en, clr);
    @(negedge clk);
    op = o; opa = a; opb = b; exec_en = en; start_clr = clr;
    #2;
    er = ref_res(o, a, b, mflag);
    ec = ref_cy(o, a, b, mflag);
    chk(result === er, (o == 5'd0 || o == 5'd2) ? "R1" : t, result, er);
    chk(illegal === !ref_legal(o), "R7", 32'(illegal), 32'(!ref_legal(o)));
    @(posedge clk);
    if (clr) mflag = 1'b0;
    else if (en && ref_arith(o)) mflag = ec;
    #2;
    chk(carry === mflag, t, 32'(carry), 32'(mflag));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #35;
    // R10 reset state
    chk(carry === 1'b0, "R10", 32'(carry), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 overflow sets flag; R1 wraps
    step(5'd0, 32'hFFFF_FFFF, 32'h1, 1, 0);
    // R2 add-with-carry consumes flag
    step(5'd1, 32'h0, 32'h0, 1, 0);
    // R4 equal operands: no borrow
    step(5'd2, 32'd5, 32'd5, 1, 0);
    step(5'd2, 32'd3, 32'd5, 1, 0);
    // R5 flag clear: extra borrow
    step(5'd3, 32'd5, 32'd5, 1, 0);
    step(5'd2, 32'd9, 32'd1, 1, 0);
    step(5'd3, 32'd7, 32'd2, 1, 0);
    // R6 logic ops keep flag=1
    for (int k = 8; k <= 12; k++) step(5'(k), 32'hF0F0_1234, 32'h0FF0_FFFF, 1, 0);
    // R7 illegal codes, enabled, flag kept
    step(5'd4, 32'hFFFF_FFFF, 32'h1, 1, 0);
    step(5'd7, 32'h1, 32'h2, 1, 0);
    step(5'd13, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0);
    step(5'd31, 32'h0, 32'h1, 1, 0);
    // R8 disabled subtract that would borrow
    step(5'd2, 32'd0, 32'd1, 0, 0);
    // R9 clear wins over enabled overflow
    step(5'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1);
    // R8 disabled overflow
    step(5'd0, 32'hFFFF_FFFF, 32'h2, 0, 0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] o;
      logic [31:0] a, b;
      o = 5'($urandom_range(0, 31));
      if ($urandom_range(0, 2) != 0) o = 5'($urandom_range(0, 3));
      a = $urandom;
      b = $urandom;
      if ($urandom_range(0, 7) == 0) b = a;
      step(o, a, b, $urandom_range(0, 3) != 0, $urandom_range(0, 31) == 0);
    end
    // R10 async reset mid-run
    step(5'd0, 32'hFFFF_FFFF, 32'h1, 1, 0);
    #3 rst_n = 1'b0;
    #2;
    mflag = 1'b0;
    chk(carry === 1'b0, "R10", 32'(carry), 0);
    rst_n = 1'b1;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule